// File: doc/BRIEF.md
# Auto-Refresh Scheduler with Deferral

This block tells a memory controller's command arbiter when an SDRAM auto-refresh is due. A free-running interval timer marks the average refresh spacing: 64 ms divided over 4096 rows gives about 15.6 us. Each mark adds one owed refresh to a debt counter. The arbiter clears the debt one refresh at a time by acknowledging the request. It may leave the request pending while it serves other traffic, and so defer up to `MAX_DEBT` refreshes. The default is eight.

When the debt reaches the limit, the urgent flag rises. The arbiter must then serve refreshes ahead of any other command. After each acknowledged refresh, a hold-off timer keeps the request low so that two refreshes are never closer than the refresh cycle time. The postponed count is visible on an output. The block does not drive SDRAM command pins.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, and right after it rises, req_o, urgent_o and debt_o are all zero.
- R2: The interval timer pulses once every INTERVAL_CYCLES clock edges. The first pulse comes at the INTERVAL_CYCLES-th edge after reset is released. Each pulse with no accepted acknowledge in the same cycle raises debt_o by one.
- R3: debt_o never exceeds MAX_DEBT. A pulse that arrives while debt_o equals MAX_DEBT and no acknowledge is accepted is lost.
- R4: urgent_o is high exactly when debt_o equals MAX_DEBT.
- R5: req_o is high exactly when debt_o is nonzero and no hold-off is running.
- R6: An ack_i sampled high while req_o is high is accepted. If no timer pulse coincides with it, debt_o falls by one at that edge.
- R7: An ack_i sampled while req_o is low is ignored. debt_o changes only by timer pulses, and no hold-off starts.
- R8: After an accepted acknowledge, req_o stays low for TRFC_CYCLES-1 cycles. Accepted acknowledges are therefore at least TRFC_CYCLES edges apart.
- R9: A timer pulse and an accepted acknowledge at the same edge leave debt_o unchanged.
- R10: The interval timer runs freely. Acknowledges never shift its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Arbiter has issued the requested refresh |
| req_o | output | 1 | A refresh is owed and may be issued now |
| urgent_o | output | 1 | Debt has reached the limit; refresh must come first |
| debt_o | output | $clog2(MAX_DEBT+1) | Number of refreshes currently postponed |

## Verification
The bench builds the block with INTERVAL_CYCLES=8, MAX_DEBT=4 and TRFC_CYCLES=3. With these values, saturation, the lost pulse at the limit, draining under constant acknowledge and the pulse/acknowledge coincidence all occur within a few dozen cycles. This lets a sweep of periodic acknowledge patterns of every period from 1 to 7, followed by a pseudo-random pattern, reach every debt level and every hold-off phase many times. The bench's arithmetic model predicts all three outputs on every cycle. Separately, the bench measures the spacing between accepted acknowledges.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned PERIOD = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = refresh_pkg::cnt_w(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (PERIOD > 1) begin : g_chk
      p_tick_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] debt_o,
  output logic          full_o
);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;

  always_comb begin
    debt_d = debt_q;
    unique case ({inc_i, dec_i})
      2'b10:   if (debt_q != LIMIT) debt_d = debt_q + 1'b1;
      2'b01:   if (debt_q != '0)    debt_d = debt_q - 1'b1;
      default: debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else         debt_q <= debt_d;
  end

  assign debt_o = debt_q;
  assign full_o = (debt_q == LIMIT);

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i && !full_o |=> debt_o == $past(debt_o) + 1'b1);
  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i && full_o |=> full_o);
  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !inc_i && debt_o != '0 |=> debt_o == $past(debt_o) - 1'b1);
  p_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && dec_i |=> $stable(debt_o));
endmodule

// File: rtl/refresh_holdoff_timer.sv
module refresh_holdoff_timer #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  generate
    if (HOLD > 1) begin : g_cnt
      localparam int unsigned W = refresh_pkg::cnt_w(HOLD);
      localparam logic [W-1:0] LOAD = W'(HOLD - 1);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (start_i)      cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end

      assign busy_o = (cnt_q != '0);

      p_busy_after_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
    end else begin : g_none
      assign busy_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned INTERVAL_CYCLES = 780,
  parameter int unsigned MAX_DEBT        = 8,
  parameter int unsigned TRFC_CYCLES     = 4,
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  output logic          req_o,
  output logic          urgent_o,
  output logic [DW-1:0] debt_o
);
  logic tick, accept, busy, full;
  logic [DW-1:0] debt;

  refresh_interval_timer #(.PERIOD(INTERVAL_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  refresh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .dec_i (accept),
    .debt_o(debt),
    .full_o(full)
  );

  refresh_holdoff_timer #(.HOLD(TRFC_CYCLES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .busy_o (busy)
  );

  // only a pending, unblocked request can be consumed
  assign accept   = ack_i & req_o;
  assign req_o    = (debt != '0) & ~busy;
  assign urgent_o = full;
  assign debt_o   = debt;

  p_urgent_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o && !busy |-> req_o);
  p_ack_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !req_o && !tick |=> $stable(debt_o));
  p_no_req_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_o == '0 |-> !req_o);

  generate
    if (TRFC_CYCLES > 1) begin : g_gap
      p_req_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> !req_o);
    end
  endgenerate
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int unsigned INTERVAL = 8;
  localparam int unsigned MAXD     = 4;
  localparam int unsigned TRFC     = 3;
  localparam int unsigned DW       = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0;
  logic req, urgent;
  logic [DW-1:0] debt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  refresh_sched #(
    .INTERVAL_CYCLES(INTERVAL),
    .MAX_DEBT       (MAXD),
    .TRFC_CYCLES    (TRFC)
  ) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ack_i   (ack),
    .req_o   (req),
    .urgent_o(urgent),
    .debt_o  (debt)
  );

  // arithmetic model from the requirements
  int m_cnt, m_debt, m_hold;
  string m_evt;
  int n_both, n_ignored, n_sat;

  function automatic bit m_req();
    return (m_debt != 0) && (m_hold == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_debt <= 0; m_hold <= 0; m_evt <= "R1";
    end else begin
      automatic bit tk  = (m_cnt == INTERVAL - 1);
      automatic bit acc = ack && m_req();
      m_cnt <= tk ? 0 : m_cnt + 1;
      if (tk && acc) begin
        m_evt <= "R9"; n_both++;
      end else if (acc) begin
        m_debt <= m_debt - 1; m_evt <= "R6";
      end else if (tk) begin
        if (m_debt < MAXD) begin m_debt <= m_debt + 1; m_evt <= "R2"; end
        else begin m_evt <= "R3"; n_sat++; end
      end else if (ack) begin
        m_evt <= "R7"; n_ignored++;
      end else m_evt <= "R10";
      m_hold <= acc ? TRFC - 1 : (m_hold > 0 ? m_hold - 1 : 0);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(m_evt, "debt_o", int'(debt), m_debt);
    chk("R4", "urgent_o", int'(urgent), int'(m_debt == MAXD));
    chk(m_hold != 0 ? "R8" : "R5", "req_o", int'(req), int'(m_req()));
  endtask

  int cyc = 0;
  int last_acc = -1000;

  // drive ack at negedge after comparing; accept happens at the next edge
  task automatic step(input bit a);
    @(negedge clk);
    cyc++;
    compare();
    ack = a;
    if (req && a) begin
      if (last_acc >= 0) chk("R8", "accept spacing ok", int'(cyc - last_acc >= TRFC), 1);
      last_acc = cyc;
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "req_o in reset", int'(req), 0);
      chk("R1", "urgent_o in reset", int'(urgent), 0);
      chk("R1", "debt_o in reset", int'(debt), 0);
    end
    rst_n = 1'b1;
    // first tick lands at edge INTERVAL after release (R2)
    for (int i = 0; i < INTERVAL - 1; i++) step(1'b0);
    step(1'b0);
    chk("R2", "debt after first interval", int'(debt), 1);
    // saturate (R3, R4)
    for (int i = 0; i < 5 * INTERVAL + 3; i++) step(1'b0);
    chk("R3", "debt saturated", int'(debt), MAXD);
    chk("R4", "urgent at limit", int'(urgent), 1);
    // constant ack drains with spacing (R6, R8, R7)
    for (int i = 0; i < 60; i++) step(1'b1);
    // periodic ack patterns (R9, R10)
    for (int p = 1; p <= 7; p++)
      for (int k = 0; k < 6 * INTERVAL; k++) step((k % p) == 0);
    // idle back to saturation, then pseudo-random
    for (int i = 0; i < 6 * INTERVAL; i++) step(1'b0);
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[2]);
    end
    step(1'b0);
    chk("R9", "coincidence seen", int'(n_both > 0), 1);
    chk("R7", "ignored ack seen", int'(n_ignored > 0), 1);
    chk("R3", "lost pulse seen", int'(n_sat > 0), 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule